// File: doc/BRIEF.md
# Letterbox Black-Line Detector

This block watches the luma stream of a video field and decides, line by line, whether each active line is black. It counts the unbroken run of black lines at the top of the field and the run of black lines that ends at the bottom. At every field strobe it stores both counts in output registers, so an external controller can read them once per field and work out the vertical zoom.

A line is judged only on a central horizontal window that software sets. A channel logo sitting at the left or right edge of a black bar therefore does not break the bar. A subtitle written into a bar lands inside the window, so that line counts as non-black and the subtitle remains on screen. The count offered for zoom is the larger of the two runs. A subtitle that shortens one bar therefore does not reduce the zoom. A dark-picture flag marks fields whose non-black content never reaches a second threshold, because such scenes cannot be told apart from the bars reliably.

Top module: `lbox_black_detect`

## Requirements
- R1: After reset, `top_cnt`, `bot_cnt` and `zoom_cnt` are 0 and `dark_pic` is 0.
- R2: A line is black when every sample whose pixel index lies in the window [`win_lo`, `win_hi`] (inclusive, counted from 0 after `line_start`) has luma strictly below `black_thr`. A single window sample equal to or above `black_thr` makes the line non-black.
- R3: Samples outside the window have no effect on the classification, however bright they are.
- R4: `top_cnt` is the number of consecutive black lines from the first line of the field up to the first non-black line. It is 0 if the first line is non-black.
- R5: `bot_cnt` is the number of consecutive black lines that end at the last line of the field. Any non-black line, a subtitle line included, restarts this run at 0.
- R6: `zoom_cnt` equals the larger of `top_cnt` and `bot_cnt`.
- R7: A line is closed by the next `line_start` or `field_start`. On `field_start` the counts of the finished field appear on the outputs after one clock edge and the internal run counters start again from zero. Between field strobes the outputs hold their values.
- R8: `dark_pic` is 1 when the highest window luma over all non-black lines of the field is below `dark_thr`. If that peak equals or exceeds `dark_thr`, the flag is 0.
- R9: When every line of the field is black, `top_cnt` and `bot_cnt` both equal the number of lines and `dark_pic` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-cycle strobe that opens a new line. A sample on the same cycle is ignored |
| field_start | input | 1 | One-cycle strobe that closes the field and latches the results |
| pix_valid | input | 1 | `pix_luma` carries a sample this cycle |
| pix_luma | input | PIX_W | Luma sample |
| black_thr | input | PIX_W | Black threshold |
| dark_thr | input | PIX_W | Dark-picture threshold |
| win_lo | input | XW | First pixel index of the window |
| win_hi | input | XW | Last pixel index of the window |
| top_cnt | output | LW | Top black-run count of the last field |
| bot_cnt | output | LW | Bottom black-run count of the last field |
| zoom_cnt | output | LW | Larger of the two counts |
| dark_pic | output | 1 | Dark low-contrast picture flag |

## Verification
The bench places samples exactly at the black threshold and a non-black peak exactly at the dark threshold. A design with an off-by-one comparison would flip the line class or the flag there. It drives bright logos just outside the window edges; a window that is one pixel too wide would cut the top run short. A single bright subtitle pixel in the bottom bar must reset the bottom run while the zoom still follows the top bar, which a design that adds or averages the runs would get wrong. An all-black field checks that the last line is closed by the field strobe itself; a design that misses this reports one line too few.

// File: rtl/lbox_black_detect.sv
module lbox_black_detect #(
  parameter int PIX_W = 8,
  parameter int XW    = 11,
  parameter int LW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             field_start,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_luma,
  input  logic [PIX_W-1:0] black_thr,
  input  logic [PIX_W-1:0] dark_thr,
  input  logic [XW-1:0]    win_lo,
  input  logic [XW-1:0]    win_hi,
  output logic [LW-1:0]    top_cnt,
  output logic [LW-1:0]    bot_cnt,
  output logic [LW-1:0]    zoom_cnt,
  output logic             dark_pic
);

  localparam logic [LW-1:0] LMAX = {LW{1'b1}};
  localparam logic [XW-1:0] XMAX = {XW{1'b1}};

  logic             line_open, line_black;
  logic [XW-1:0]    x_pos;
  logic [PIX_W-1:0] line_peak, fld_peak;
  logic [LW-1:0]    top_acc, bot_acc, lines_acc;
  logic             in_top, nb_seen;

  logic             strobe, close, in_win, take;
  logic [LW-1:0]    top_n, bot_n, lines_n;
  logic             in_top_n, nb_n;
  logic [PIX_W-1:0] peak_n;

  assign strobe = line_start | field_start;
  assign close  = strobe & line_open;
  assign in_win = (x_pos >= win_lo) && (x_pos <= win_hi);
  assign take   = pix_valid & line_open & ~strobe;

  assign top_n    = (close && line_black && in_top && top_acc != LMAX) ? top_acc + 1'b1 : top_acc;
  assign in_top_n = in_top & ~(close & ~line_black);
  assign bot_n    = !close ? bot_acc :
                    !line_black ? '0 :
                    (bot_acc != LMAX) ? bot_acc + 1'b1 : bot_acc;
  assign lines_n  = (close && lines_acc != LMAX) ? lines_acc + 1'b1 : lines_acc;
  assign nb_n     = nb_seen | (close & ~line_black);
  assign peak_n   = (close && !line_black && line_peak > fld_peak) ? line_peak : fld_peak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_open  <= 1'b0;
      line_black <= 1'b1;
      x_pos      <= '0;
      line_peak  <= '0;
    end else if (line_start) begin
      line_open  <= 1'b1;
      line_black <= 1'b1;
      x_pos      <= '0;
      line_peak  <= '0;
    end else if (field_start) begin
      line_open  <= 1'b0;
    end else if (take) begin
      if (x_pos != XMAX) x_pos <= x_pos + 1'b1;
      if (in_win) begin
        if (pix_luma >= black_thr) line_black <= 1'b0;
        if (pix_luma > line_peak)  line_peak  <= pix_luma;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_acc   <= '0;
      bot_acc   <= '0;
      lines_acc <= '0;
      in_top    <= 1'b1;
      nb_seen   <= 1'b0;
      fld_peak  <= '0;
      top_cnt   <= '0;
      bot_cnt   <= '0;
      zoom_cnt  <= '0;
      dark_pic  <= 1'b0;
    end else if (field_start) begin
      top_cnt   <= top_n;
      bot_cnt   <= bot_n;
      zoom_cnt  <= (top_n > bot_n) ? top_n : bot_n;
      dark_pic  <= !nb_n || (peak_n < dark_thr);
      top_acc   <= '0;
      bot_acc   <= '0;
      lines_acc <= '0;
      in_top    <= 1'b1;
      nb_seen   <= 1'b0;
      fld_peak  <= '0;
    end else begin
      top_acc   <= top_n;
      bot_acc   <= bot_n;
      lines_acc <= lines_n;
      in_top    <= in_top_n;
      nb_seen   <= nb_n;
      fld_peak  <= peak_n;
    end
  end

  p_runs_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (top_acc <= lines_acc) && (bot_acc <= lines_acc));

  p_bottom_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (close && !line_black && !field_start) |=> (bot_acc == '0));

  p_zoom_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (zoom_cnt >= top_cnt) && (zoom_cnt >= bot_cnt) &&
    ((zoom_cnt == top_cnt) || (zoom_cnt == bot_cnt)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> ($stable(top_cnt) && $stable(bot_cnt) && $stable(dark_pic)));

  p_no_content_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && !nb_n) |=> dark_pic);

  p_all_black_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && lines_n != '0 && top_n == lines_n) |=> (bot_cnt == top_cnt && dark_pic));

endmodule

// File: tb/tb_lbox_black_detect.sv
module tb_lbox_black_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_start = 1'b0, field_start = 1'b0, pix_valid = 1'b0;
  logic [7:0] pix_luma = '0, black_thr = 8'd16, dark_thr = 8'd64;
  logic [10:0] win_lo = 11'd4, win_hi = 11'd11;
  logic [9:0] top_cnt, bot_cnt, zoom_cnt;
  logic       dark_pic;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  lbox_black_detect dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_start(field_start),
    .pix_valid(pix_valid), .pix_luma(pix_luma), .black_thr(black_thr), .dark_thr(dark_thr),
    .win_lo(win_lo), .win_hi(win_hi), .top_cnt(top_cnt), .bot_cnt(bot_cnt),
    .zoom_cnt(zoom_cnt), .dark_pic(dark_pic));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_line(input logic [7:0] edge_v, input logic [7:0] mid_v,
                           input int spike_x, input logic [7:0] spike_v);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int x = 0; x < 16; x++) begin
      pix_valid = 1'b1;
      if (x == spike_x)         pix_luma = spike_v;
      else if (x < 4 || x > 11) pix_luma = edge_v;
      else                      pix_luma = mid_v;
      @(negedge clk);
    end
    pix_valid = 1'b0;
  endtask

  task automatic blk(input int n);
    for (int i = 0; i < n; i++) send_line(8'd5, 8'd5, 99, 8'd0);
  endtask

  task automatic bright(input int n);
    for (int i = 0; i < n; i++) send_line(8'd200, 8'd200, 99, 8'd0);
  endtask

  task automatic end_field;
    field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 top", top_cnt, 0);
    chk("R1 bot", bot_cnt, 0);
    chk("R1 zoom", zoom_cnt, 0);
    chk("R1 dark", dark_pic, 0);
  endtask

  task automatic t_basic;
    blk(3); bright(4); blk(2); end_field;
    chk("R4 top", top_cnt, 3);
    chk("R5 bot", bot_cnt, 2);
    chk("R6 zoom", zoom_cnt, 3);
    chk("R8 dark bright", dark_pic, 0);
  endtask

  task automatic t_logos;
    for (int i = 0; i < 4; i++) send_line(8'd255, 8'd5, 99, 8'd0);
    send_line(8'd5, 8'd5, 3, 8'd250);
    send_line(8'd5, 8'd5, 12, 8'd250);
    chk("R7 hold top", top_cnt, 3);
    chk("R7 hold bot", bot_cnt, 2);
    bright(2);
    for (int i = 0; i < 5; i++) send_line(8'd255, 8'd5, 99, 8'd0);
    end_field;
    chk("R3 top with logos", top_cnt, 6);
    chk("R3 bot with logos", bot_cnt, 5);
    chk("R6 zoom", zoom_cnt, 6);
  endtask

  task automatic t_threshold;
    send_line(8'd5, 8'd15, 99, 8'd0);
    blk(1);
    send_line(8'd5, 8'd5, 11, 8'd16);
    blk(1);
    end_field;
    chk("R2 top at threshold", top_cnt, 2);
    chk("R2 bot at threshold", bot_cnt, 1);
  endtask

  task automatic t_subtitle;
    blk(3); bright(3); blk(2);
    send_line(8'd5, 8'd5, 7, 8'd220);
    blk(2); end_field;
    chk("R5 bot after subtitle", bot_cnt, 2);
    chk("R4 top", top_cnt, 3);
    chk("R6 zoom follows top", zoom_cnt, 3);
    bright(1); blk(4); end_field;
    chk("R4 first line bright", top_cnt, 0);
    chk("R6 zoom follows bot", zoom_cnt, 4);
  endtask

  task automatic t_dark;
    blk(2);
    for (int i = 0; i < 3; i++) send_line(8'd5, 8'd40, 99, 8'd0);
    end_field;
    chk("R8 dark low peak", dark_pic, 1);
    chk("R5 bot zero", bot_cnt, 0);
    blk(2);
    send_line(8'd5, 8'd40, 6, 8'd64);
    end_field;
    chk("R8 dark peak at threshold", dark_pic, 0);
  endtask

  task automatic t_all_black;
    blk(6); end_field;
    chk("R9 top", top_cnt, 6);
    chk("R9 bot", bot_cnt, 6);
    chk("R9 zoom", zoom_cnt, 6);
    chk("R9 dark", dark_pic, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_logos;
    t_threshold;
    t_subtitle;
    t_dark;
    t_all_black;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule